// File: doc/BRIEF.md
# Biphase Mark Stereo Audio Line Transmitter

This block turns a stream of stereo PCM sample pairs into a single self-clocked line signal that uses consumer digital audio framing. Every frame holds a left subframe followed by a right subframe. Each subframe is 32 slots long. It opens with a 4-slot sync preamble, which deliberately breaks the biphase rule. The 24-bit audio field follows, and the subframe closes with a validity flag, a user flag, one channel-status bit and an even-parity bit. Slots are coded with biphase mark: the line toggles at the start of every slot, and a 1 adds a second toggle mid-slot.

Timing comes from a half-slot ("cell") clock enable, `cell_en`, which must pulse at 128 times the audio sample rate, so 6.144 MHz at 48 kHz. Sample pairs enter through a valid/ready handshake into a one-deep holding slot. That slot is emptied once per frame. If no fresh pair has arrived, the previous pair is repeated with the validity flag raised. The 192-bit channel-status word is a static register input. Bit n of it travels in both subframes of frame n of each 192-frame block.

Top module: `bmc_audio_tx`

## Requirements
- R1: `smp_ready` is high exactly when the one-deep holding slot is empty. A pair accepted at a clock edge is sent in the next frame whose start follows a later frame boundary, that is, the edge that emits the final cell of a right subframe. A pair accepted on that boundary edge itself waits one further frame.
- R2: The line changes only on an edge where `cell_en` is high. Each subframe spans 64 cells, which are 32 slots of two cells each, and the left subframe is sent before the right one.
- R3: Audio occupies slots 4 to 27, least significant bit first, so slot 4 carries field bit 0. An input narrower than 24 bits (`IN_W`) is MSB-justified, with zeros filling the low field bits.
- R4: In slots 4 to 31 the line toggles at the start of each slot, and it toggles again at mid-slot exactly when the slot's bit is 1.
- R5: Preamble cells 0 to 7, taken relative to the line level before cell 0, are B = 11101000, M = 11100010 and W = 11100100, with the first cell listed first. When that level is high, the complemented pattern is sent.
- R6: Slot 31 is set so that slots 4 to 31 hold an even number of ones. As a result, every subframe ends at line level 0 from reset onward.
- R7: Frames are numbered modulo `BLOCK_FRAMES` (default 192). The left subframe of frame 0 uses preamble B, the other left subframes use M, and every right subframe uses W.
- R8: Slot 30 of both subframes of frame n carries `chan_status[n]`.
- R9: Slot 28 carries `flag_validity` OR stale, and slot 29 carries `flag_user`. Both flags are sampled at the frame boundary that starts the frame.
- R10: A frame that starts with no held pair repeats the previous audio and sets slot 28 to 1. The first frame after reset sends zero audio with slot 28 set to 1 and slot 29 set to 0.
- R11: While reset is held, `line_out` is 0 and `smp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_en | input | 1 | Half-slot enable, 128 x sample rate |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding slot empty |
| smp_left | input | IN_W | Left (channel 1) sample |
| smp_right | input | IN_W | Right (channel 2) sample |
| flag_validity | input | 1 | Validity flag request |
| flag_user | input | 1 | User data bit |
| chan_status | input | BLOCK_FRAMES | Channel-status word, bit n for frame n |
| line_out | output | 1 | Biphase-mark line signal |

## Verification
The bench feeds a 20-bit configuration for a little over two full blocks and decodes every subframe back from the line. It checks each preamble against the block position, which catches a design that forgets to send B at the block wrap or that mixes up M and W. It decodes each audio field against the padding and LSB-first order, where a reversed order or an unpadded field corrupts every sample. It also runs gaps in sample supply, so a design that stalls, or that repeats a sample without raising validity, shows wrong audio or flags. Parity and the level at each subframe end are checked on every subframe, and a wrong parity term leaves the line at the wrong polarity. The later part of the run uses a sparse `cell_en`, so any drift between enables shows up.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

   localparam int AUDIO_W       = 24;
   localparam int CELLS_PER_SUB = 64;
   localparam int PRE_CELLS     = 8;
   localparam int DATA_SLOTS    = 28;
   localparam int FIRST_DATA    = 4;

   typedef enum logic [1:0] {
      SYNC_BLOCK = 2'd0,
      SYNC_LEFT  = 2'd1,
      SYNC_RIGHT = 2'd2
   } sync_kind_e;

   typedef struct packed {
      logic [AUDIO_W-1:0] left;
      logic [AUDIO_W-1:0] right;
      logic               vflag;
      logic               uflag;
      logic               stale;
   } frame_payload_t;

   function automatic logic [PRE_CELLS-1:0] sync_cells(sync_kind_e kind);
      logic [PRE_CELLS-1:0] pat;
      case (kind)
         SYNC_BLOCK: pat = 8'b1110_1000;
         SYNC_LEFT:  pat = 8'b1110_0010;
         default:    pat = 8'b1110_0100;
      endcase
      return pat;
   endfunction

endpackage

// File: rtl/bmc_sample_stage.sv
module bmc_sample_stage
   import bmc_tx_pkg::*;
#(
   parameter int IN_W = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_valid,
   output logic           smp_ready,
   input  logic [IN_W-1:0] smp_left,
   input  logic [IN_W-1:0] smp_right,
   input  logic           flag_validity,
   input  logic           flag_user,
   input  logic           load_frame,
   output frame_payload_t payload
);

   localparam int PAD_W = AUDIO_W - IN_W;

   logic [AUDIO_W-1:0] wide_l, wide_r;
   logic [AUDIO_W-1:0] hold_l, hold_r;
   logic               hold_full;
   logic               accept;

   generate
      if (PAD_W == 0) begin : g_direct
         assign wide_l = smp_left;
         assign wide_r = smp_right;
      end else begin : g_pad
         assign wide_l = {smp_left,  {PAD_W{1'b0}}};
         assign wide_r = {smp_right, {PAD_W{1'b0}}};
      end
   endgenerate

   assign smp_ready = ~hold_full;
   assign accept    = smp_valid & ~hold_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_l    <= '0;
         hold_r    <= '0;
      end else begin
         if (accept) begin
            hold_l    <= wide_l;
            hold_r    <= wide_r;
            hold_full <= 1'b1;
         end else if (load_frame) begin
            hold_full <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         payload.left  <= '0;
         payload.right <= '0;
         payload.vflag <= 1'b0;
         payload.uflag <= 1'b0;
         payload.stale <= 1'b1;
      end else if (load_frame) begin
         payload.vflag <= flag_validity;
         payload.uflag <= flag_user;
         if (hold_full) begin
            payload.left  <= hold_l;
            payload.right <= hold_r;
            payload.stale <= 1'b0;
         end else begin
            payload.stale <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/bmc_slot_seq.sv
module bmc_slot_seq
   import bmc_tx_pkg::*;
#(
   parameter int BLOCK_FRAMES = 192,
   parameter int FRAME_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cell_en,
   output logic [5:0]         cell_idx,
   output logic               sub_sel,
   output logic [FRAME_W-1:0] frame_idx,
   output logic               frame_end
);

   localparam logic [5:0]         LAST_CELL  = 6'(CELLS_PER_SUB - 1);
   localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(BLOCK_FRAMES - 1);

   logic sub_end;

   assign sub_end   = cell_en && (cell_idx == LAST_CELL);
   assign frame_end = sub_end && sub_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cell_idx  <= '0;
         sub_sel   <= 1'b0;
         frame_idx <= '0;
      end else if (cell_en) begin
         cell_idx <= cell_idx + 6'd1;
         if (sub_end) begin
            sub_sel <= ~sub_sel;
         end
         if (frame_end) begin
            frame_idx <= (frame_idx == LAST_FRAME) ? '0 : frame_idx + FRAME_W'(1);
         end
      end
   end

endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder
   import bmc_tx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cell_en,
   input  logic                 pre_active,
   input  logic [2:0]           pre_idx,
   input  logic [PRE_CELLS-1:0] pre_pattern,
   input  logic                 half,
   input  logic                 data_bit,
   output logic                 line_out
);

   logic line_q, ref_q, ref_now, next_level;

   assign ref_now = (pre_idx == 3'd0) ? line_q : ref_q;

   always_comb begin
      if (pre_active) begin
         next_level = pre_pattern[3'd7 - pre_idx] ^ ref_now;
      end else if (!half) begin
         next_level = ~line_q;
      end else begin
         next_level = data_bit ? ~line_q : line_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         ref_q  <= 1'b0;
      end else if (cell_en) begin
         line_q <= next_level;
         if (pre_active && (pre_idx == 3'd0)) begin
            ref_q <= line_q;
         end
      end
   end

   assign line_out = line_q;

endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
   import bmc_tx_pkg::*;
#(
   parameter int IN_W         = 24,
   parameter int BLOCK_FRAMES = 192
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cell_en,
   input  logic                    smp_valid,
   output logic                    smp_ready,
   input  logic [IN_W-1:0]         smp_left,
   input  logic [IN_W-1:0]         smp_right,
   input  logic                    flag_validity,
   input  logic                    flag_user,
   input  logic [BLOCK_FRAMES-1:0] chan_status,
   output logic                    line_out
);

   localparam int FRAME_W = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1;

   generate
      if (IN_W < 16 || IN_W > AUDIO_W) begin : g_bad_width
         $error("bmc_audio_tx: IN_W must lie in 16..24");
      end
      if (BLOCK_FRAMES < 2) begin : g_bad_block
         $error("bmc_audio_tx: BLOCK_FRAMES must be at least 2");
      end
   endgenerate

   logic [5:0]           cell_idx;
   logic                 sub_sel;
   logic [FRAME_W-1:0]   frame_idx;
   logic                 frame_end;
   frame_payload_t       payload;

   logic [4:0]            slot;
   logic [4:0]            data_idx;
   logic                  pre_active;
   logic                  half;
   sync_kind_e            kind;
   logic [PRE_CELLS-1:0]  pre_pattern;
   logic [AUDIO_W-1:0]    audio;
   logic                  v_bit, u_bit, c_bit, p_bit;
   logic [DATA_SLOTS-1:0] data_word;
   logic                  data_bit;

   bmc_sample_stage #(.IN_W(IN_W)) u_stage (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_valid     (smp_valid),
      .smp_ready     (smp_ready),
      .smp_left      (smp_left),
      .smp_right     (smp_right),
      .flag_validity (flag_validity),
      .flag_user     (flag_user),
      .load_frame    (frame_end),
      .payload       (payload)
   );

   bmc_slot_seq #(.BLOCK_FRAMES(BLOCK_FRAMES), .FRAME_W(FRAME_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cell_en   (cell_en),
      .cell_idx  (cell_idx),
      .sub_sel   (sub_sel),
      .frame_idx (frame_idx),
      .frame_end (frame_end)
   );

   assign slot       = cell_idx[5:1];
   assign half       = cell_idx[0];
   assign pre_active = (slot < 5'(FIRST_DATA));
   assign data_idx   = pre_active ? 5'd0 : (slot - 5'(FIRST_DATA));

   always_comb begin
      if (sub_sel) begin
         kind = SYNC_RIGHT;
      end else if (frame_idx == '0) begin
         kind = SYNC_BLOCK;
      end else begin
         kind = SYNC_LEFT;
      end
   end

   assign pre_pattern = sync_cells(kind);

   assign audio     = sub_sel ? payload.right : payload.left;
   assign v_bit     = payload.vflag | payload.stale;
   assign u_bit     = payload.uflag;
   assign c_bit     = chan_status[frame_idx];
   assign p_bit     = ^{c_bit, u_bit, v_bit, audio};
   assign data_word = {p_bit, c_bit, u_bit, v_bit, audio};
   assign data_bit  = data_word[data_idx];

   bmc_line_coder u_coder (
      .clk         (clk),
      .rst_n       (rst_n),
      .cell_en     (cell_en),
      .pre_active  (pre_active),
      .pre_idx     (cell_idx[2:0]),
      .pre_pattern (pre_pattern),
      .half        (half),
      .data_bit    (data_bit),
      .line_out    (line_out)
   );

endmodule

// File: rtl/bmc_tx_checker.sv
module bmc_tx_checker #(
   parameter int BLOCK_FRAMES = 192,
   parameter int FRAME_W      = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cell_en,
   input logic               line_out,
   input logic               smp_valid,
   input logic               smp_ready,
   input logic [5:0]         cell_idx,
   input logic               sub_sel,
   input logic [FRAME_W-1:0] frame_idx
);

   a_r2_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_en |=> $stable(line_out));

   a_r4_slot_start_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_en && cell_idx >= 6'd8 && !cell_idx[0]) |=> (line_out != $past(line_out)));

   a_r5_preamble_flat: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_en && cell_idx == 6'd2) |=> $stable(line_out));

   a_r6_subframe_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_en && cell_idx == 6'd0) |-> !line_out);

   a_r7_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(frame_idx) < BLOCK_FRAMES);

   a_r7_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_en && cell_idx == 6'd63 && sub_sel && int'(frame_idx) == BLOCK_FRAMES - 1)
      |=> (frame_idx == '0));

   a_r1_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ready) |=> !smp_ready);

endmodule

bind bmc_audio_tx bmc_tx_checker #(
   .BLOCK_FRAMES (BLOCK_FRAMES),
   .FRAME_W      (FRAME_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cell_en   (cell_en),
   .line_out  (line_out),
   .smp_valid (smp_valid),
   .smp_ready (smp_ready),
   .cell_idx  (cell_idx),
   .sub_sel   (sub_sel),
   .frame_idx (frame_idx)
);

// File: tb/tb_bmc_audio_tx.sv
module tb_bmc_audio_tx;

   localparam int IN_W    = 20;
   localparam int BLOCK   = 192;
   localparam int NFRAMES = 390;
   localparam int CPF     = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cell_en = 1'b0;
   logic smp_valid = 1'b0;
   logic [IN_W-1:0] smp_left = '0;
   logic [IN_W-1:0] smp_right = '0;
   logic flag_validity = 1'b0;
   logic flag_user = 1'b0;
   logic [BLOCK-1:0] chan_status;
   logic smp_ready;
   logic line_out;

   always #10 clk = ~clk;

   bmc_audio_tx #(.IN_W(IN_W), .BLOCK_FRAMES(BLOCK)) dut (
      .clk(clk), .rst_n(rst_n), .cell_en(cell_en),
      .smp_valid(smp_valid), .smp_ready(smp_ready),
      .smp_left(smp_left), .smp_right(smp_right),
      .flag_validity(flag_validity), .flag_user(flag_user),
      .chan_status(chan_status), .line_out(line_out)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic [23:0] exp_l [0:NFRAMES+2];
   logic [23:0] exp_r [0:NFRAMES+2];
   bit exp_v [0:NFRAMES+2];
   bit exp_u [0:NFRAMES+2];
   bit exp_stale [0:NFRAMES+2];

   logic cells [0:63];
   int ncell = 0;
   int nsub = 0;
   logic start_lvl = 1'b0;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [IN_W-1:0] samp_l(int k);
      if (k % 50 == 7) return '1;
      if (k % 50 == 8) return '0;
      return IN_W'((k * 32'h9E3779B1) >> 7);
   endfunction

   function automatic logic [IN_W-1:0] samp_r(int k);
      return ~samp_l(k) ^ IN_W'(k << 3);
   endfunction

   function automatic logic [23:0] widen(logic [IN_W-1:0] s);
      return 24'(s) << (24 - IN_W);
   endfunction

   task automatic decode_sub();
      int f;
      bit sub;
      logic [7:0] pat;
      logic [27:0] bits;
      logic [23:0] aud;
      int bad_pre;
      int bad_tog;
      logic prev;
      string areq;
      f   = nsub / 2;
      sub = nsub[0];
      if (sub) pat = 8'b1110_0100;
      else if (f % BLOCK == 0) pat = 8'b1110_1000;
      else pat = 8'b1110_0010;
      bad_pre = 0;
      for (int i = 0; i < 8; i++)
         if (cells[i] !== (pat[7-i] ^ start_lvl)) bad_pre++;
      check(bad_pre == 0, "R5 R7", $sformatf("preamble f=%0d sub=%0d", f, sub), bad_pre, 0);
      bad_tog = 0;
      for (int s = 4; s < 32; s++) begin
         prev = cells[2*s-1];
         if (cells[2*s] === prev) bad_tog++;
         bits[s-4] = cells[2*s] ^ cells[2*s+1];
      end
      check(bad_tog == 0, "R4", $sformatf("slot-start toggles f=%0d", f), bad_tog, 0);
      for (int i = 0; i < 24; i++) aud[i] = bits[i];
      areq = exp_stale[f] ? "R10" : "R3";
      if (sub)
         check(aud == exp_r[f], areq, $sformatf("right audio f=%0d", f), aud, exp_r[f]);
      else
         check(aud == exp_l[f], areq, $sformatf("left audio f=%0d", f), aud, exp_l[f]);
      check(bits[24] == exp_v[f], exp_stale[f] ? "R10" : "R9",
            $sformatf("validity f=%0d", f), bits[24], exp_v[f]);
      check(bits[25] == exp_u[f], "R9", $sformatf("user f=%0d", f), bits[25], exp_u[f]);
      check(bits[26] == chan_status[f % BLOCK], "R8", $sformatf("status f=%0d", f),
            bits[26], chan_status[f % BLOCK]);
      check((^bits) == 1'b0, "R6", $sformatf("parity f=%0d", f), ^bits, 0);
      check(cells[63] == 1'b0, "R6", $sformatf("end level f=%0d", f), cells[63], 0);
      start_lvl = cells[63];
      nsub++;
   endtask

   task automatic record(logic lv);
      cells[ncell] = lv;
      ncell++;
      if (ncell == 64) begin
         decode_sub();
         ncell = 0;
      end
   endtask

   initial begin
      logic [23:0] m_l, m_r, h_l, h_r;
      bit m_stale, h_full, rdy_prev, accepted;
      logic prev_line;
      int cells_done, k, fr, nf;
      for (int i = 0; i < BLOCK; i++)
         chan_status[i] = (i == 0) || (i == BLOCK - 1) || ((i * 7) % 5 == 1);
      m_l = '0; m_r = '0; h_l = '0; h_r = '0;
      m_stale = 1'b1; h_full = 1'b0;
      exp_l[0] = '0; exp_r[0] = '0; exp_v[0] = 1'b1; exp_u[0] = 1'b0; exp_stale[0] = 1'b1;
      cells_done = 0; k = 0;
      repeat (3) @(negedge clk);
      check(line_out == 1'b0, "R11", "line in reset", line_out, 0);
      check(smp_ready == 1'b1, "R11", "ready in reset", smp_ready, 1);
      rst_n = 1'b1;
      rdy_prev = smp_ready;
      prev_line = line_out;
      smp_left = samp_l(0);
      smp_right = samp_r(0);
      smp_valid = 1'b1;
      cell_en = 1'b1;
      for (int cyc = 0; cells_done < NFRAMES * CPF; cyc++) begin
         @(negedge clk);
         if (cell_en) begin
            record(line_out);
            if (cells_done % CPF == CPF - 1) begin
               nf = cells_done / CPF + 1;
               if (h_full) begin
                  m_l = h_l; m_r = h_r; m_stale = 1'b0; h_full = 1'b0;
               end else begin
                  m_stale = 1'b1;
               end
               exp_l[nf] = m_l; exp_r[nf] = m_r;
               exp_v[nf] = flag_validity | m_stale;
               exp_u[nf] = flag_user;
               exp_stale[nf] = m_stale;
            end
            cells_done++;
         end else begin
            check(line_out == prev_line, "R2", "line moved without enable", line_out, prev_line);
         end
         accepted = smp_valid && rdy_prev;
         if (accepted) begin
            h_l = widen(smp_left); h_r = widen(smp_right); h_full = 1'b1;
            k++;
         end
         check(smp_ready == !h_full, "R1", "ready vs holding slot", smp_ready, !h_full);
         rdy_prev = smp_ready;
         prev_line = line_out;
         fr = cells_done / CPF;
         smp_left = samp_l(k);
         smp_right = samp_r(k);
         smp_valid = !((fr >= 40 && fr < 46) || (fr >= 250 && fr < 253) || fr == 120);
         flag_validity = (fr % 17 == 5);
         flag_user = cyc[5];
         cell_en = (fr < 300) ? 1'b1 : (cyc % 3 == 0);
      end
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule